// File: doc/BRIEF.md
# Output-Compare Timer Channel with Shared Pin

This block is one output-compare timer channel that shares a single port pin with a general-purpose output latch. A free-running up-counter advances on every clock. Software arms the channel by writing a compare register with the present count plus a tick interval. When the count reaches that value, the channel raises an event flag and, depending on a two-bit action field, toggles, clears or sets its own output level.

Pin ownership is decided by two controls. While the channel is enabled as an output compare, the compare logic owns the pin even when the action field selects "no action". The pin only returns to the general-purpose latch when a separate detach bit is set. With the detach bit set, compare events and the interrupt keep working, while writes to the port latch appear on the pin.

Registers sit behind a synchronous write port with a combinational read port. The control register is at address 0: bit 0 enables output compare, bit 1 enables the interrupt, bits 3:2 hold the action field, and bit 4 is the detach bit. The compare value is at address 1, the port latch is at bit 0 of address 2, the event flag is at bit 0 of address 3, and address 4 reads the live counter.

Top module: `oc_pin_channel`

## Requirements
- R1: After reset, all registers read zero, the counter is 0, `irq` is 0, and `pin_out` follows the port latch (0).
- R2: The counter increments by one on every clock, wraps from 0xFFFF to 0x0000, and reads back at address 4.
- R3: A match occurs when control bit 0 is set and the counter equals the compare register. On the clock edge after a match, bit 0 of address 3 becomes 1. When control bit 0 is clear, equality produces no match.
- R4: The event flag is set by a match whatever the interrupt enable is. Writing a 1 to bit 0 of address 3 clears the flag. Writing a 0 there leaves the flag unchanged. If a match and a clear land on the same edge, the set takes priority.
- R5: `irq` is 1 exactly when the event flag is 1 and control bit 1 is 1.
- R6: Action field 01 toggles the channel output level, 10 drives it to 0, and 11 drives it to 1. The new level takes effect on the clock edge after the match.
- R7: Action field 00 leaves the channel output level unchanged on a match. While control bit 0 is 1 and bit 4 is 0, the pin still shows the channel level and ignores the port latch.
- R8: With control bits 0 and 4 both set, `pin_out` follows the port latch. Matches still set the flag and raise `irq`, and the channel level keeps updating. That level shows on the pin once bit 4 is cleared.
- R9: With control bit 0 clear, `pin_out` follows the port latch whatever the action field and the detach bit hold.
- R10: A compare value that wrapped past 0xFFFF during the addition matches once the counter wraps and reaches it.
- R11: The control, compare, port and flag registers read back their current contents at their addresses. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| pin_out | output | 1 | Shared pin level |
| irq | output | 1 | Interrupt request |

## Verification
A register write, the counter step, the flag and the channel output level all change on the rising edge after the cycle that causes them. Reads, `irq` and the pin multiplexer are combinational on top of that state. The bench keeps a behavioural model that advances on each rising edge from the same inputs, and it compares `pin_out`, `irq` and `bus_rdata` on every falling edge. Inputs change 1 ns after a falling edge, so every comparison sees settled state one edge after its cause. The same-edge set-and-clear case is timed by waiting until the model's count equals the compare value before issuing the clear.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [1:0] {
    OC_HOLD   = 2'b00,
    OC_TOGGLE = 2'b01,
    OC_CLEAR  = 2'b10,
    OC_SET    = 2'b11
  } oc_mode_e;

  // control register image, bit 4 down to bit 0
  typedef struct packed {
    logic     detach;
    oc_mode_e mode;
    logic     irq_en;
    logic     oc_sel;
  } oc_ctrl_t;

  localparam int CTRL_W = $bits(oc_ctrl_t);

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_CMP  = 3'd1;
  localparam logic [2:0] ADDR_PORT = 3'd2;
  localparam logic [2:0] ADDR_STAT = 3'd3;
  localparam logic [2:0] ADDR_CNT  = 3'd4;

  // level of the channel output after an event with the given action
  function automatic logic oc_next_level(oc_mode_e m, logic cur);
    case (m)
      OC_TOGGLE: return ~cur;
      OC_CLEAR:  return 1'b0;
      OC_SET:    return 1'b1;
      default:   return cur;
    endcase
  endfunction

  // who drives the pin: 1 = compare logic, 0 = port latch
  function automatic logic oc_owns_pin(oc_ctrl_t c);
    return c.oc_sel & ~c.detach;
  endfunction

endpackage

// File: rtl/oc_free_counter.sv
module oc_free_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + STEP;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count == CNT_W'($past(count) + STEP));

endmodule

// File: rtl/oc_regs.sv
module oc_regs
  import oc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              match_evt,
  input  logic [CNT_W-1:0]  count,
  output oc_ctrl_t          ctrl,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              port_bit,
  output logic              flag,
  output logic [CNT_W-1:0]  rdata
);

  logic wr_ctrl, wr_cmp, wr_port, flag_clr;

  assign wr_ctrl  = wr_en && (addr == ADDR_W'(ADDR_CTRL));
  assign wr_cmp   = wr_en && (addr == ADDR_W'(ADDR_CMP));
  assign wr_port  = wr_en && (addr == ADDR_W'(ADDR_PORT));
  assign flag_clr = wr_en && (addr == ADDR_W'(ADDR_STAT)) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      cmp_val  <= '0;
      port_bit <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl     <= oc_ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_cmp)  cmp_val  <= wdata;
      if (wr_port) port_bit <= wdata[0];
    end
  end

  // a match on the same edge as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (match_evt) flag <= 1'b1;
    else if (flag_clr)  flag <= 1'b0;
  end

  always_comb begin
    case (addr)
      ADDR_W'(ADDR_CTRL): rdata = CNT_W'(ctrl);
      ADDR_W'(ADDR_CMP):  rdata = cmp_val;
      ADDR_W'(ADDR_PORT): rdata = CNT_W'(port_bit);
      ADDR_W'(ADDR_STAT): rdata = CNT_W'(flag);
      ADDR_W'(ADDR_CNT):  rdata = count;
      default:            rdata = '0;
    endcase
  end

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag);

  // R4
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match_evt) |=> !flag);

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_clr && !match_evt) |=> $stable(flag));

endmodule

// File: rtl/oc_compare_unit.sv
module oc_compare_unit
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp_val,
  input  oc_ctrl_t         ctrl,
  output logic             match_evt,
  output logic             oc_level
);

  logic cnt_eq;

  assign cnt_eq    = (count == cmp_val);
  assign match_evt = ctrl.oc_sel & cnt_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         oc_level <= 1'b0;
    else if (match_evt) oc_level <= oc_next_level(ctrl.mode, oc_level);
  end

  // R6
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && ctrl.mode == OC_TOGGLE) |=> oc_level != $past(oc_level));

  // R6
  set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && ctrl.mode == OC_SET) |=> oc_level);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && ctrl.mode == OC_CLEAR) |=> !oc_level);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_evt || ctrl.mode == OC_HOLD) |=> $stable(oc_level));

endmodule

// File: rtl/oc_pin_channel.sv
module oc_pin_channel
  import oc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              pin_out,
  output logic              irq
);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cmp_val;
  oc_ctrl_t         ctrl;
  logic             port_bit;
  logic             flag;
  logic             match_evt;
  logic             oc_level;
  logic             timer_owns;

  oc_free_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .count (count)
  );

  oc_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .match_evt (match_evt),
    .count     (count),
    .ctrl      (ctrl),
    .cmp_val   (cmp_val),
    .port_bit  (port_bit),
    .flag      (flag),
    .rdata     (bus_rdata)
  );

  oc_compare_unit #(.CNT_W(CNT_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .cmp_val   (cmp_val),
    .ctrl      (ctrl),
    .match_evt (match_evt),
    .oc_level  (oc_level)
  );

  assign timer_owns = oc_owns_pin(ctrl);
  assign pin_out    = timer_owns ? oc_level : port_bit;
  assign irq        = flag & ctrl.irq_en;

  // R3
  no_match_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.oc_sel |-> !match_evt);

  // R5
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  // R8
  detached_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.detach |-> pin_out == port_bit);

endmodule

// File: tb/sim_oc_pin_channel.sv
`timescale 1ns/1ps
module sim_oc_pin_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        pin_out, irq;

  always #2.5 clk = ~clk;

  oc_pin_channel u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .irq(irq)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference
  int m_cnt, m_cmp;
  bit m_sel, m_ie, m_det, m_port, m_flag, m_oc;
  bit [1:0] m_mode;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_sel = 0; m_ie = 0; m_det = 0;
      m_port = 0; m_flag = 0; m_oc = 0; m_mode = 0;
    end else begin
      bit hit;
      hit = m_sel && (m_cnt == m_cmp);
      if (hit) begin
        m_flag = 1;
        if (m_mode == 2'd1) m_oc = !m_oc;
        else if (m_mode == 2'd2) m_oc = 0;
        else if (m_mode == 2'd3) m_oc = 1;
      end else if (bus_wr && bus_addr == 3'd3 && bus_wdata[0]) m_flag = 0;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: begin
            m_sel = bus_wdata[0]; m_ie = bus_wdata[1];
            m_mode = bus_wdata[3:2]; m_det = bus_wdata[4];
          end
          3'd1: m_cmp = int'(bus_wdata);
          3'd2: m_port = bus_wdata[0];
          default: ;
        endcase
      end
      m_cnt = (m_cnt + 1) % 65536;
    end
  end

  function automatic int exp_rdata(logic [2:0] a);
    case (a)
      3'd0: return {m_det, m_mode, m_ie, m_sel};
      3'd1: return m_cmp;
      3'd2: return int'(m_port);
      3'd3: return int'(m_flag);
      3'd4: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "pin_out", int'(pin_out),
            int'((m_sel && !m_det) ? m_oc : m_port));
      check(cur_req, "irq", int'(irq), int'(m_flag && m_ie));
      check(cur_req, "rdata", int'(bus_rdata), exp_rdata(bus_addr));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, int d);
    @(negedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = 16'(d);
    @(negedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a);
    @(negedge clk); #1;
    bus_addr = a;
    @(negedge clk); #1;
  endtask

  // ctrl image: bit0 select, bit1 irq enable, bits3:2 action, bit4 detach
  function automatic int ctrl_word(bit sel, bit ie, bit [1:0] md, bit det);
    return {det, md, ie, sel};
  endfunction

  task automatic arm(int ahead);
    wr(3'd1, (m_cnt + ahead) % 65536);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    // R1 reset values
    cur_req = "R1";
    @(negedge clk);
    check("R1", "pin at reset", int'(pin_out), 0);
    check("R1", "irq at reset", int'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd(3'(a));
      check("R1", "reg reset", int'(bus_rdata), 0);
    end

    // R2 counter reads
    cur_req = "R2";
    rd(3'd4);
    idle(5);

    // R11 readback, R9 select off
    cur_req = "R11";
    wr(3'd0, ctrl_word(0, 1, 2'd3, 0));
    rd(3'd0);
    wr(3'd1, 16'h5A3C);
    rd(3'd1);
    wr(3'd2, 1);
    rd(3'd2);
    rd(3'd6);
    cur_req = "R9";
    wr(3'd1, (m_cnt + 4) % 65536);
    idle(10);
    check("R9", "pin follows latch", int'(pin_out), 1);
    rd(3'd3);
    check("R3", "no flag with select off", int'(bus_rdata), 0);
    wr(3'd0, ctrl_word(0, 0, 2'd1, 1));
    wr(3'd2, 0);
    idle(3);

    // R3 / R6 set action, interrupt disabled
    cur_req = "R6";
    wr(3'd0, ctrl_word(1, 0, 2'd3, 0));
    arm(20);
    rd(3'd3);
    idle(25);
    check("R6", "set action", int'(pin_out), 1);
    cur_req = "R4";
    check("R4", "flag without enable", int'(bus_rdata), 1);
    check("R5", "irq masked", int'(irq), 0);

    // R5 enable
    cur_req = "R5";
    wr(3'd0, ctrl_word(1, 1, 2'd3, 0));
    idle(2);
    check("R5", "irq raised", int'(irq), 1);
    cur_req = "R4";
    wr(3'd3, 0);
    check("R4", "write 0 keeps flag", int'(irq), 1);
    wr(3'd3, 1);
    check("R4", "write 1 clears flag", int'(irq), 0);

    // R6 toggle then clear
    cur_req = "R6";
    wr(3'd0, ctrl_word(1, 1, 2'd1, 0));
    arm(15);
    idle(20);
    check("R6", "toggle", int'(pin_out), 0);
    arm(15);
    idle(20);
    check("R6", "toggle back", int'(pin_out), 1);
    wr(3'd0, ctrl_word(1, 1, 2'd2, 0));
    arm(15);
    idle(20);
    check("R6", "clear action", int'(pin_out), 0);
    wr(3'd3, 1);

    // R7 no action keeps the timer on the pin
    cur_req = "R7";
    wr(3'd0, ctrl_word(1, 1, 2'd0, 0));
    wr(3'd2, 1);
    arm(12);
    idle(16);
    check("R7", "pin ignores latch", int'(pin_out), 0);
    check("R7", "flag still set", int'(irq), 1);
    wr(3'd3, 1);

    // R8 detach
    cur_req = "R8";
    wr(3'd0, ctrl_word(1, 1, 2'd1, 1));
    check("R8", "latch on pin", int'(pin_out), 1);
    wr(3'd2, 0);
    check("R8", "port clear on pin", int'(pin_out), 0);
    arm(12);
    wr(3'd2, 1);
    idle(16);
    check("R8", "irq while detached", int'(irq), 1);
    check("R8", "pin still latch", int'(pin_out), 1);
    wr(3'd2, 0);
    wr(3'd0, ctrl_word(1, 1, 2'd1, 0));
    check("R8", "toggled level shows", int'(pin_out), 1);
    wr(3'd3, 1);

    // R4 set beats clear on same edge
    cur_req = "R4";
    begin
      int tgt;
      tgt = (m_cnt + 14) % 65536;
      wr(3'd1, tgt);
      do begin @(negedge clk); #1; end while (m_cnt != tgt);
      bus_wr = 1; bus_addr = 3'd3; bus_wdata = 16'd1;
      @(negedge clk); #1;
      bus_wr = 0;
      check("R4", "set wins", int'(bus_rdata), 1);
    end
    wr(3'd3, 1);

    // R10 wrap of compare value, R2 counter wrap
    cur_req = "R2";
    wr(3'd0, ctrl_word(1, 1, 2'd3, 0));
    wr(3'd2, 1);
    rd(3'd4);
    while (m_cnt < 65500) begin @(negedge clk); #1; end
    cur_req = "R10";
    wr(3'd0, ctrl_word(1, 1, 2'd2, 0));
    arm(70);
    wr(3'd3, 1);
    rd(3'd4);
    idle(30);
    check("R10", "no early match", int'(irq), 0);
    idle(50);
    check("R10", "match after wrap", int'(irq), 1);
    check("R10", "clear action after wrap", int'(pin_out), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    done = 1;
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule